// File: doc/BRIEF.md
# NAND Page Programming Order Monitor

This block sits beside a NAND flash controller and judges every program and erase request before it reaches the flash. For each block of the array it tracks the next page that may be programmed. For the page most recently opened in that block, it also records which 512-byte main-area sectors and which 16-byte spare-area chunks have already had a partial program since the page was opened. A program request is allowed only if it targets the next page, or re-targets the page opened last, and touches no sector or chunk that was already programmed on that page. An erase always succeeds and returns its block to the empty state.

The monitor is a small state machine. After reset it sits in `ST_INIT` and writes an empty entry into every block slot, one slot per cycle. When the last slot is cleared it moves to `ST_IDLE`, where `mon_idle` is high. In `ST_IDLE` a request with `req_valid` high is latched and the machine moves to `ST_EVAL`. In `ST_EVAL` the block's entry is read and judged. If the request is allowed, the updated entry is written back. The verdict is registered, and the machine returns to `ST_IDLE`. A request is therefore answered by a one-cycle `resp_valid` pulse in the cycle after the second rising edge following acceptance.

Top module: `nand_pom_top`

## Requirements
- R1: After reset the monitor spends exactly BLOCKS cycles in `ST_INIT`, with `mon_idle` and `resp_valid` low. Afterwards every block has next page 0 and no sector or chunk marked.
- R2: A request is taken only on a rising edge where `req_valid` and `mon_idle` are both high. Requests presented at any other time are ignored. Each accepted request produces exactly one `resp_valid` pulse, in the cycle after the second rising edge following acceptance.
- R3: An erase (`req_op` = 1) is always allowed with code 2'b00. It resets its block to next page 0 and clears all sector and chunk marks.
- R4: A program (`req_op` = 0) whose page equals the block's next page, while the next page is below PAGES, opens that page. The next page advances by one. The page's marks become exactly the sectors and chunks this request touches.
- R5: A program to the page one below the next page is a repeated partial program of the open page. The next page stays unchanged, and the marks it touches are added to those already present.
- R6: A program to any other page is denied with code 2'b01. Once a block is full (next page = PAGES), only page PAGES-1 remains programmable.
- R7: The request covers bytes `req_col` through `req_col + req_len` inclusive. Bytes 0..2047 form four 512-byte main sectors, sector i being bytes 512*i..512*i+511. Touching a sector already marked on the target page is denied with code 2'b10.
- R8: Bytes 2048..2111 form four 16-byte spare chunks, chunk i being bytes 2048+16*i..2048+16*i+15. Bytes above 2111 touch nothing. Touching a chunk already marked on the target page is denied with code 2'b11.
- R9: When several faults apply, the reported code follows the priority order 2'b01, then 2'b10, then 2'b11. A denied request changes no stored state.
- R10: `resp_allow` is high exactly when `resp_code` is 2'b00. Each block's state is independent of requests to other blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 1 | 0 = program, 1 = erase |
| req_block | input | $clog2(BLOCKS) | Target block |
| req_page | input | $clog2(PAGES) | Target page within the block |
| req_col | input | 12 (derived) | First byte column of the program |
| req_len | input | 12 (derived) | Byte count minus one |
| mon_idle | output | 1 | High in `ST_IDLE`; a request can be taken |
| resp_valid | output | 1 | One-cycle verdict pulse |
| resp_allow | output | 1 | Request is permitted |
| resp_code | output | 2 | 00 ok, 01 page order, 10 main sector reuse, 11 spare chunk reuse |

## Verification
The bench goes after a full block, where only the last page may be re-entered. A design with an off-by-one pointer would either allow a program past the end or reject the last page. It probes spans that end exactly on a sector or chunk boundary, where a wrong comparison would mark one sector too many or too few. It checks requests that break several rules at once; a wrong priority would report the sector or chunk code instead of the order code. It also checks that a denied request leaves the marks untouched, and that requests arriving during `ST_INIT` or `ST_EVAL` are dropped. A design that latched a request while busy would change a block behind the bench's back, and a later legal program would then be refused.

// File: rtl/nand_pom_pkg.sv
package nand_pom_pkg;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_IDLE = 2'd1,
        ST_EVAL = 2'd2
    } pom_state_e;

    typedef enum logic [1:0] {
        VC_NONE  = 2'b00,
        VC_ORDER = 2'b01,
        VC_MAIN  = 2'b10,
        VC_SPARE = 2'b11
    } pom_code_e;

    localparam logic OP_PROGRAM = 1'b0;
    localparam logic OP_ERASE   = 1'b1;

endpackage

// File: rtl/nand_pom_span.sv
// Maps a byte span onto the main sectors and spare chunks it overlaps.
module nand_pom_span #(
    parameter int SECTORS      = 4,
    parameter int SECTOR_BYTES = 512,
    parameter int CHUNKS       = 4,
    parameter int CHUNK_BYTES  = 16,
    parameter int COL_W        = 12
) (
    input  logic [COL_W-1:0]   col,
    input  logic [COL_W-1:0]   len,
    output logic [SECTORS-1:0] main_hit,
    output logic [CHUNKS-1:0]  spare_hit
);
    localparam int EW        = COL_W + 1;
    localparam int MAIN_SIZE = SECTORS * SECTOR_BYTES;

    logic [EW-1:0] first_b;
    logic [EW-1:0] last_b;

    assign first_b = {1'b0, col};
    assign last_b  = {1'b0, col} + {1'b0, len};

    for (genvar s = 0; s < SECTORS; s++) begin : g_sector
        localparam int LO = s * SECTOR_BYTES;
        localparam int HI = LO + SECTOR_BYTES - 1;
        assign main_hit[s] = (first_b <= EW'(HI)) && (last_b >= EW'(LO));
    end

    for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
        localparam int LO = MAIN_SIZE + c * CHUNK_BYTES;
        localparam int HI = LO + CHUNK_BYTES - 1;
        assign spare_hit[c] = (first_b <= EW'(HI)) && (last_b >= EW'(LO));
    end

endmodule

// File: rtl/nand_pom_judge.sv
// Pure decision logic: verdict and successor entry for one request.
module nand_pom_judge
    import nand_pom_pkg::*;
#(
    parameter int PAGES   = 64,
    parameter int SECTORS = 4,
    parameter int CHUNKS  = 4,
    parameter int PG_W    = 6,
    parameter int PTR_W   = 7
) (
    input  logic               is_erase,
    input  logic [PG_W-1:0]    page,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [SECTORS-1:0] main_mask,
    input  logic [CHUNKS-1:0]  spare_mask,
    input  logic [SECTORS-1:0] main_hit,
    input  logic [CHUNKS-1:0]  spare_hit,
    output logic               allow,
    output logic [1:0]         code,
    output logic [PTR_W-1:0]   nxt_ptr,
    output logic [SECTORS-1:0] nxt_main,
    output logic [CHUNKS-1:0]  nxt_spare
);
    logic               fresh;
    logic               again;
    logic [SECTORS-1:0] base_main;
    logic [CHUNKS-1:0]  base_spare;

    always_comb begin
        fresh      = ({1'b0, page} == ptr) && (ptr < PTR_W'(PAGES));
        again      = (ptr != '0) && ({1'b0, page} == (ptr - PTR_W'(1)));
        base_main  = fresh ? '0 : main_mask;
        base_spare = fresh ? '0 : spare_mask;

        allow     = 1'b1;
        code      = VC_NONE;
        nxt_ptr   = ptr;
        nxt_main  = base_main | main_hit;
        nxt_spare = base_spare | spare_hit;

        if (is_erase) begin
            nxt_ptr   = '0;
            nxt_main  = '0;
            nxt_spare = '0;
        end else if (!(fresh || again)) begin
            allow = 1'b0;
            code  = VC_ORDER;
        end else if (|(main_hit & base_main)) begin
            allow = 1'b0;
            code  = VC_MAIN;
        end else if (|(spare_hit & base_spare)) begin
            allow = 1'b0;
            code  = VC_SPARE;
        end else if (fresh) begin
            nxt_ptr = ptr + PTR_W'(1);
        end
    end

endmodule

// File: rtl/nand_pom_table.sv
// Per-block state store: one write port, one asynchronous read port.
module nand_pom_table #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 15,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/nand_pom_top.sv
module nand_pom_top
    import nand_pom_pkg::*;
#(
    parameter int BLOCKS       = 1024,
    parameter int PAGES        = 64,
    parameter int SECTORS      = 4,
    parameter int SECTOR_BYTES = 512,
    parameter int CHUNKS       = 4,
    parameter int CHUNK_BYTES  = 16,
    localparam int BLK_W       = $clog2(BLOCKS),
    localparam int PG_W        = $clog2(PAGES),
    localparam int COL_W       = $clog2(SECTORS * SECTOR_BYTES + CHUNKS * CHUNK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_op,
    input  logic [BLK_W-1:0] req_block,
    input  logic [PG_W-1:0]  req_page,
    input  logic [COL_W-1:0] req_col,
    input  logic [COL_W-1:0] req_len,
    output logic             mon_idle,
    output logic             resp_valid,
    output logic             resp_allow,
    output logic [1:0]       resp_code
);
    localparam int PTR_W = PG_W + 1;
    localparam int ENT_W = PTR_W + SECTORS + CHUNKS;

    pom_state_e       state_q;
    pom_state_e       state_d;
    logic [BLK_W-1:0] clr_q;

    logic             op_q;
    logic [BLK_W-1:0] blk_q;
    logic [PG_W-1:0]  page_q;
    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] len_q;

    logic [ENT_W-1:0]   cur_ent;
    logic [ENT_W-1:0]   wr_ent;
    logic               wr_en;
    logic [BLK_W-1:0]   wr_addr;

    logic [PTR_W-1:0]   cur_ptr;
    logic [SECTORS-1:0] cur_main;
    logic [CHUNKS-1:0]  cur_spare;
    logic [SECTORS-1:0] hit_main;
    logic [CHUNKS-1:0]  hit_spare;

    logic               j_allow;
    logic [1:0]         j_code;
    logic [PTR_W-1:0]   j_ptr;
    logic [SECTORS-1:0] j_main;
    logic [CHUNKS-1:0]  j_spare;

    // State register with request latch and clear sweep index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            clr_q   <= '0;
            op_q    <= OP_PROGRAM;
            blk_q   <= '0;
            page_q  <= '0;
            col_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INIT) begin
                clr_q <= clr_q + BLK_W'(1);
            end
            if (state_q == ST_IDLE && req_valid) begin
                op_q   <= req_op;
                blk_q  <= req_block;
                page_q <= req_page;
                col_q  <= req_col;
                len_q  <= req_len;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: if (clr_q == BLK_W'(BLOCKS - 1)) state_d = ST_IDLE;
            ST_IDLE: if (req_valid) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
            default: state_d = ST_INIT;
        endcase
    end

    // Registered verdict outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
            resp_code  <= VC_NONE;
        end else begin
            resp_valid <= (state_q == ST_EVAL);
            resp_allow <= (state_q == ST_EVAL) && j_allow;
            resp_code  <= (state_q == ST_EVAL) ? j_code : VC_NONE;
        end
    end

    assign mon_idle = (state_q == ST_IDLE);

    assign {cur_ptr, cur_main, cur_spare} = cur_ent;

    assign wr_en   = (state_q == ST_INIT) || ((state_q == ST_EVAL) && j_allow);
    assign wr_addr = (state_q == ST_INIT) ? clr_q : blk_q;
    assign wr_ent  = (state_q == ST_INIT) ? '0 : {j_ptr, j_main, j_spare};

    nand_pom_table #(
        .DEPTH (BLOCKS),
        .WIDTH (ENT_W),
        .AW    (BLK_W)
    ) u_table (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_ent),
        .rd_addr (blk_q),
        .rd_data (cur_ent)
    );

    nand_pom_span #(
        .SECTORS      (SECTORS),
        .SECTOR_BYTES (SECTOR_BYTES),
        .CHUNKS       (CHUNKS),
        .CHUNK_BYTES  (CHUNK_BYTES),
        .COL_W        (COL_W)
    ) u_span (
        .col       (col_q),
        .len       (len_q),
        .main_hit  (hit_main),
        .spare_hit (hit_spare)
    );

    nand_pom_judge #(
        .PAGES   (PAGES),
        .SECTORS (SECTORS),
        .CHUNKS  (CHUNKS),
        .PG_W    (PG_W),
        .PTR_W   (PTR_W)
    ) u_judge (
        .is_erase   (op_q == OP_ERASE),
        .page       (page_q),
        .ptr        (cur_ptr),
        .main_mask  (cur_main),
        .spare_mask (cur_spare),
        .main_hit   (hit_main),
        .spare_hit  (hit_spare),
        .allow      (j_allow),
        .code       (j_code),
        .nxt_ptr    (j_ptr),
        .nxt_main   (j_main),
        .nxt_spare  (j_spare)
    );

endmodule

// File: rtl/nand_pom_chk.sv
module nand_pom_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_op,
    input logic       mon_idle,
    input logic       resp_valid,
    input logic       resp_allow,
    input logic [1:0] resp_code
);
    AST_INIT_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !mon_idle); // R1

    AST_RESP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid == $past(req_valid && mon_idle, 2)); // R2

    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R2

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mon_idle) |=> !mon_idle); // R2

    AST_ERASE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && $past(req_op, 2)) |-> (resp_allow && resp_code == 2'b00)); // R3

    AST_ALLOW_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_allow == (resp_code == 2'b00))); // R10

endmodule

bind nand_pom_top nand_pom_chk u_chk (.*);

// File: tb/nand_pom_top_test.sv
module nand_pom_top_test;
    localparam int BLOCKS = 4;
    localparam int PAGES  = 8;
    localparam int SECS   = 4;
    localparam int SBYTES = 512;
    localparam int CHKS   = 4;
    localparam int CBYTES = 16;
    localparam int MAINSZ = SECS * SBYTES;
    localparam int BW     = 2;
    localparam int PW     = 3;
    localparam int CW     = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_op = 1'b0;
    logic [BW-1:0] req_block = '0;
    logic [PW-1:0] req_page = '0;
    logic [CW-1:0] req_col = '0;
    logic [CW-1:0] req_len = '0;
    logic          mon_idle;
    logic          resp_valid;
    logic          resp_allow;
    logic [1:0]    resp_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int m_ptr   [BLOCKS];
    int m_main  [BLOCKS];
    int m_spare [BLOCKS];
    logic [31:0] seed = 32'h1d2c_3b4a;

    always #4 clk = ~clk;

    nand_pom_top #(
        .BLOCKS(BLOCKS), .PAGES(PAGES), .SECTORS(SECS),
        .SECTOR_BYTES(SBYTES), .CHUNKS(CHKS), .CHUNK_BYTES(CBYTES)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_block(req_block), .req_page(req_page), .req_col(req_col),
        .req_len(req_len), .mon_idle(mon_idle), .resp_valid(resp_valid),
        .resp_allow(resp_allow), .resp_code(resp_code)
    );

    function automatic int span_mask(int col, int len, bit spare);
        int m = 0;
        for (int i = 0; i < 4; i++) begin
            int lo = spare ? MAINSZ + i * CBYTES : i * SBYTES;
            int hi = lo + (spare ? CBYTES : SBYTES) - 1;
            if (col <= hi && col + len >= lo) m |= (1 << i);
        end
        return m;
    endfunction

    function automatic logic [31:0] next_rnd(logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13;
        x ^= x >> 17;
        x ^= x << 5;
        return x;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Issue one request, compare the verdict with the arithmetic model, update the model.
    task automatic do_req(input bit op, input int blk, input int pg,
                          input int col, input int len, input string lbl);
        bit fresh, again, eallow;
        logic [1:0] ecode;
        int mh, sh, bm, bs;
        string tag;
        mh = span_mask(col, len, 1'b0);
        sh = span_mask(col, len, 1'b1);
        fresh = (pg == m_ptr[blk]) && (m_ptr[blk] < PAGES);
        again = (m_ptr[blk] > 0) && (pg == m_ptr[blk] - 1);
        bm = fresh ? 0 : m_main[blk];
        bs = fresh ? 0 : m_spare[blk];
        if (op) begin ecode = 2'b00; tag = "R3"; end
        else if (!(fresh || again)) begin ecode = 2'b01; tag = "R6"; end
        else if ((mh & bm) != 0) begin ecode = 2'b10; tag = "R7"; end
        else if ((sh & bs) != 0) begin ecode = 2'b11; tag = "R8"; end
        else begin ecode = 2'b00; tag = fresh ? "R4" : "R5"; end
        eallow = (ecode == 2'b00);

        @(negedge clk);
        while (!mon_idle) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_block = BW'(blk);
        req_page  = PW'(pg);
        req_col   = CW'(col);
        req_len   = CW'(len);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (resp_valid !== 1'b1 || resp_allow !== eallow || resp_code !== ecode) begin
            errors++;
            $display("FAIL %s/%s blk=%0d pg=%0d col=%0d len=%0d: got v=%0b a=%0b c=%0b expected v=1 a=%0b c=%0b",
                     lbl, tag, blk, pg, col, len, resp_valid, resp_allow, resp_code, eallow, ecode);
        end
        if (eallow) begin
            if (op) begin
                m_ptr[blk] = 0; m_main[blk] = 0; m_spare[blk] = 0;
            end else begin
                if (fresh) m_ptr[blk] = m_ptr[blk] + 1;
                m_main[blk]  = bm | mh;
                m_spare[blk] = bs | sh;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < BLOCKS; b++) begin
            m_ptr[b] = 0; m_main[b] = 0; m_spare[b] = 0;
        end
        repeat (3) @(negedge clk);
        // Hold a request during the clear sweep: it must be dropped (R2).
        req_valid = 1'b1; req_op = 1'b0; req_block = '0; req_page = '0;
        req_col = '0; req_len = 12'd10;
        rst_n = 1'b1;
        check_bit("R1 idle low after reset", mon_idle, 1'b0);
        check_bit("R1 no response after reset", resp_valid, 1'b0);
        repeat (BLOCKS - 1) @(negedge clk);
        req_valid = 1'b0;
        check_bit("R1 still clearing", mon_idle, 1'b0);
        check_bit("R2 no response during clear", resp_valid, 1'b0);
        @(negedge clk);
        check_bit("R1 idle after sweep", mon_idle, 1'b1);
        check_bit("R2 init request dropped", resp_valid, 1'b0);

        // Block 0 must still be empty: page 0 opens, page 1 is next.
        do_req(1'b0, 0, 0, 0, 10, "R1 block0 open");

        // Block 1: order, sector and chunk rules.
        do_req(1'b0, 1, 1, 0, 0, "R6 skip page");
        do_req(1'b0, 1, 0, 0, 511, "R4 open sector0");
        do_req(1'b0, 1, 0, 512, 511, "R5 add sector1");
        do_req(1'b0, 1, 0, 100, 10, "R7 reuse sector0");
        do_req(1'b0, 1, 0, 511, 1, "R7 boundary 511-512");
        do_req(1'b0, 1, 0, MAINSZ, 15, "R8 chunk0");
        do_req(1'b0, 1, 0, MAINSZ + 12, 0, "R8 reuse chunk0");
        do_req(1'b0, 1, 0, 300, 2000, "R9 main before spare");
        do_req(1'b0, 1, 3, 0, 0, "R9 order before main");
        do_req(1'b0, 1, 0, 1024, 1023, "R9 deny left state");
        do_req(1'b0, 1, 0, MAINSZ + 16, 47, "R8 chunks1-3");
        do_req(1'b0, 1, 0, MAINSZ + 63, 200, "R8 past end");

        // Block 2: fill to the end, then erase.
        for (int p = 0; p < PAGES; p++) do_req(1'b0, 2, p, 0, MAINSZ - 1, "R4 fill");
        do_req(1'b0, 2, PAGES - 1, MAINSZ + 50, 20, "R6 full block last page");
        do_req(1'b0, 2, 0, MAINSZ, 0, "R6 full block page0");
        do_req(1'b0, 2, PAGES - 1, 0, 0, "R7 full block sector");
        do_req(1'b1, 2, 5, 0, 0, "R3 erase");
        do_req(1'b0, 2, 1, 0, 0, "R3 erase resets order");
        do_req(1'b0, 2, 0, 0, 0, "R3 after erase open");

        // R10 independence: block 3 unaffected by blocks 1 and 2.
        do_req(1'b0, 3, 0, 700, 5, "R10 independent block");

        // R2: request held into ST_EVAL must be ignored.
        @(negedge clk);
        while (!mon_idle) @(negedge clk);
        req_valid = 1'b1; req_op = 1'b0; req_block = 2'd3; req_page = 3'd1;
        req_col = '0; req_len = 12'd5;
        @(negedge clk);
        req_op = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_bit("R2 first verdict", resp_valid, 1'b1);
        check_bit("R2 first verdict allow", resp_allow, 1'b1);
        m_ptr[3] = 2; m_main[3] = 1; m_spare[3] = 0;
        @(negedge clk);
        check_bit("R2 no second verdict", resp_valid, 1'b0);
        do_req(1'b0, 3, 2, 0, 0, "R2 busy erase dropped");

        // Sweep of mixed requests over all blocks.
        for (int n = 0; n < 1500; n++) begin
            int blk, kind, pg, col, len;
            seed = next_rnd(seed);
            blk  = int'(seed % BLOCKS);
            kind = int'((seed >> 4) % 8);
            pg = m_ptr[blk];
            if (kind >= 4 && kind < 6) pg = m_ptr[blk] - 1;
            if (kind >= 6) pg = int'((seed >> 8) % PAGES);
            if (pg >= PAGES) pg = PAGES - 1;
            if (pg < 0) pg = 0;
            if (seed[12]) begin
                col = int'((seed >> 14) % (MAINSZ + 64));
                len = int'((seed >> 20) % 700);
            end else begin
                col = MAINSZ + int'((seed >> 14) % 64);
                len = int'((seed >> 20) % 24);
            end
            do_req(kind == 0, blk, pg, col, len, "sweep");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule